// File: doc/BRIEF.md
# Speculative Register Checkpoint and Gated Store Unit

This block holds a small register file in two copies. The working copy is read and written by execution. The shadow copy holds the last checkpoint. Next to the register file sits a gated store buffer. Store requests are queued there and do not reach memory until they are made permanent. The two parts act together, so that register state and memory writes form one group that is either kept or thrown away.

A commit command does two things. It copies every working register into its shadow register in one clock. It also releases the stores queued so far, and these then drain to the memory write port in FIFO order, one per cycle. A rollback command also does two things. It copies every shadow register back into the working copy in one clock. It also discards the stores that were never released.

Loads present an address to the buffer. The buffer returns the data of the youngest queued store to the same address, so that loads see the speculative memory image. A store into a full buffer is refused and flagged with a stall.

Top module: `spc_ckpt_unit`

## Requirements
- R1: After reset every working and shadow register reads zero, the buffer is empty, `cmt_ready` is 1, `mem_we` is 0 and `ld_hit` is 0.
- R2: A write on `wr_en` updates working register `wr_idx` at the clock edge. `rd_data` shows working register `rd_idx` combinationally.
- R3: An accepted commit copies all working registers into the shadow copy at one edge. A register write in the same cycle as the commit lands only in the working copy, so it belongs to the next checkpoint.
- R4: A rollback copies all shadow registers back into the working copy at one edge. A register write in the same cycle as the rollback is discarded.
- R5: Stores (`st_req`) are only queued. `mem_we` stays 0 while no released store is pending.
- R6: An accepted commit releases every store queued before that cycle. A store in the commit cycle is not released. Released stores appear on `mem_we`/`mem_addr`/`mem_data` one per cycle in arrival order, starting the cycle after the commit.
- R7: `cmt_ready` is 0 while released stores are still draining. A commit in that state is ignored entirely: no shadow update and no release.
- R8: A rollback drops every unreleased store, including one requested in the rollback cycle. Stores already released keep draining.
- R9: With `SB_DEPTH` entries occupied, `st_req` raises `st_stall` in the same cycle and the store is not queued.
- R10: `ld_hit`/`ld_data` report combinationally the youngest queued store (released or not) whose address equals `ld_addr`. `ld_hit` is 0 when no entry matches.
- R11: Commit and rollback asserted together act as a rollback alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_idx | input | $clog2(NREG) | Working register read index |
| rd_data | output | DW | Working register read data |
| wr_en | input | 1 | Working register write enable |
| wr_idx | input | $clog2(NREG) | Working register write index |
| wr_data | input | DW | Working register write data |
| st_req | input | 1 | Store enqueue request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store refused, buffer full |
| ld_addr | input | AW | Load forwarding lookup address |
| ld_hit | output | 1 | A queued store matches `ld_addr` |
| ld_data | output | DW | Data of youngest matching store |
| commit | input | 1 | Checkpoint command |
| rollback | input | 1 | Restore command |
| cmt_ready | output | 1 | A commit would be accepted |
| mem_we | output | 1 | Memory write strobe for a draining store |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |

## Verification
Some results are combinational on the current state and inputs, and these are due in the same cycle as the stimulus: `rd_data`, `ld_hit`/`ld_data`, `st_stall` and `cmt_ready`. Register copies, queue changes and the start of a drain appear one edge later, and the drain then delivers one entry per following cycle. The bench drives its inputs on the falling edge and samples every output 1 ns later, against a model state. It advances that model only at the rising edge, so each check compares against the state in force after the last edge. Random commands, stores and loads over a narrow address range are mixed with directed sequences for each corner: writes in a commit or rollback cycle, both commands together, a commit during a drain, a rollback during a drain, and a full buffer.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    CK_IDLE     = 2'd0,
    CK_COMMIT   = 2'd1,
    CK_ROLLBACK = 2'd2
  } ckpt_op_e;

  // Rollback wins over commit; commit only counts when the drain is idle.
  function automatic ckpt_op_e pick_op(logic cmt, logic rb, logic ready);
    if (rb)
      return CK_ROLLBACK;
    if (cmt && ready)
      return CK_COMMIT;
    return CK_IDLE;
  endfunction

endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic rollback,
  input  logic cmt_ready,
  output logic do_commit,
  output logic do_rollback
);

  ckpt_op_e op;

  always_comb begin
    op          = pick_op(commit, rollback, cmt_ready);
    do_commit   = (op == CK_COMMIT);
    do_rollback = (op == CK_ROLLBACK);
  end

  AST_RB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> (do_rollback && !do_commit)); // R11

  AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cmt_ready) |-> !do_commit); // R7

endmodule

// File: rtl/spc_regfile.sv
module spc_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RIW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [RIW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data,
  input  logic           do_commit,
  input  logic           do_rollback
);

  logic [DW-1:0] work_q [NREG];
  logic [DW-1:0] shad_q [NREG];

  assign rd_data = work_q[rd_idx];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr_hit;
    assign wr_hit = wr_en && (wr_idx == RIW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work_q[g] <= '0;
      end else if (do_rollback) begin
        work_q[g] <= shad_q[g];
      end else if (wr_hit) begin
        work_q[g] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shad_q[g] <= '0;
      end else if (do_commit) begin
        shad_q[g] <= work_q[g];
      end
    end

    AST_CMT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      do_commit |=> (shad_q[g] == $past(work_q[g]))); // R3

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !do_commit |=> $stable(shad_q[g])); // R3

    AST_RB_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      do_rollback |=> (work_q[g] == $past(shad_q[g]))); // R4
  end

endmodule

// File: rtl/spc_store_buf.sv
module spc_store_buf #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_req,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          do_commit,
  input  logic          do_rollback,
  output logic          cmt_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);

  // DEPTH must be a power of two (pointer wrap by truncation).
  function automatic logic [PW-1:0] ptr_add(logic [PW-1:0] p, logic [CW-1:0] n);
    return p + PW'(n);
  endfunction

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q, head_n, tail_n;
  logic [CW-1:0] count_q, cmt_q, count_n, cmt_n;

  // Named internal events.
  logic full, push, pop;

  assign full      = (count_q == CW'(DEPTH));
  assign pop       = (cmt_q != '0);
  assign push      = st_req && !full && !do_rollback;
  assign st_stall  = st_req && full;
  assign cmt_ready = (cmt_q == '0);
  assign mem_we    = pop;
  assign mem_addr  = addr_q[head_q];
  assign mem_data  = data_q[head_q];

  always_comb begin
    head_n = head_q + PW'(pop);
    if (do_rollback) begin
      cmt_n   = cmt_q - CW'(pop);
      count_n = cmt_n;
      tail_n  = ptr_add(head_q, cmt_q);
    end else begin
      count_n = count_q + CW'(push) - CW'(pop);
      tail_n  = tail_q + PW'(push);
      cmt_n   = do_commit ? count_q : (cmt_q - CW'(pop));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      cmt_q   <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
      cmt_q   <= cmt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= st_addr;
      data_q[tail_q] <= st_data;
    end
  end

  // Oldest to youngest; a later match overrides, so the youngest wins.
  always_comb begin
    ld_hit  = 1'b0;
    ld_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < count_q) && (addr_q[ptr_add(head_q, CW'(i))] == ld_addr)) begin
        ld_hit  = 1'b1;
        ld_data = data_q[ptr_add(head_q, CW'(i))];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH)); // R9

  AST_STALL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |=> (count_q <= $past(count_q))); // R9

  AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_q == '0 && !do_commit) |=> !mem_we); // R5

  AST_COMMIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> (cmt_q == $past(count_q))); // R6

  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (cmt_q == $past(cmt_q) - CW'(1))); // R6

  AST_CMT_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_q <= count_q); // R6

  AST_RB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    do_rollback |=> (count_q == cmt_q)); // R8

endmodule

// File: rtl/spc_ckpt_unit.sv
module spc_ckpt_unit #(
  parameter int NREG     = 8,
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int SB_DEPTH = 4,
  localparam int RIW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RIW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data,
  input  logic           wr_en,
  input  logic [RIW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           st_req,
  input  logic [AW-1:0]  st_addr,
  input  logic [DW-1:0]  st_data,
  output logic           st_stall,
  input  logic [AW-1:0]  ld_addr,
  output logic           ld_hit,
  output logic [DW-1:0]  ld_data,
  input  logic           commit,
  input  logic           rollback,
  output logic           cmt_ready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data
);

  logic do_commit, do_rollback;

  spc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .rollback    (rollback),
    .cmt_ready   (cmt_ready),
    .do_commit   (do_commit),
    .do_rollback (do_rollback)
  );

  spc_regfile #(.NREG(NREG), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .do_commit   (do_commit),
    .do_rollback (do_rollback)
  );

  spc_store_buf #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_sbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_req      (st_req),
    .st_addr     (st_addr),
    .st_data     (st_data),
    .st_stall    (st_stall),
    .ld_addr     (ld_addr),
    .ld_hit      (ld_hit),
    .ld_data     (ld_data),
    .do_commit   (do_commit),
    .do_rollback (do_rollback),
    .cmt_ready   (cmt_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data)
  );

endmodule

// File: tb/test_spc_ckpt_unit.sv
`timescale 1ns/1ps
module test_spc_ckpt_unit;
  localparam int NREG = 8, DW = 32, AW = 16, SBD = 4, RIW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RIW-1:0] rd_idx, wr_idx;
  logic [DW-1:0]  rd_data, wr_data, st_data, ld_data, mem_data;
  logic [AW-1:0]  st_addr, ld_addr, mem_addr;
  logic wr_en, st_req, st_stall, ld_hit, commit, rollback, cmt_ready, mem_we;

  always #2 clk = ~clk;

  spc_ckpt_unit #(.NREG(NREG), .DW(DW), .AW(AW), .SB_DEPTH(SBD)) i_spc_ckpt_unit (.*);

  int checks = 0, errors = 0, cyc = 0;
  string t_rd = "R2", t_ld = "R10";

  // Drive values for the next cycle.
  logic d_we, d_st, d_cm, d_rb;
  logic [RIW-1:0] d_widx, d_ridx;
  logic [DW-1:0] d_wdata, d_sdata;
  logic [AW-1:0] d_saddr, d_laddr;

  // Model state.
  logic [DW-1:0] wk [NREG];
  logic [DW-1:0] sh [NREG];
  logic [AW-1:0] qa [$];
  logic [DW-1:0] qd [$];
  int ncmt = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clr();
    d_we = 0; d_st = 0; d_cm = 0; d_rb = 0;
  endtask

  task automatic model_update();
    bit pop, rb, cm, full;
    pop  = ncmt > 0;
    rb   = d_rb;
    cm   = d_cm && !rb && ncmt == 0;
    full = qa.size() == SBD;
    if (rb) wk = sh;
    else begin
      if (cm) sh = wk;
      if (d_we) wk[d_widx] = d_wdata;
    end
    if (pop) begin void'(qa.pop_front()); void'(qd.pop_front()); ncmt--; end
    if (rb) begin
      while (qa.size() > ncmt) begin void'(qa.pop_back()); void'(qd.pop_back()); end
    end else begin
      if (cm) ncmt = qa.size();
      if (d_st && !full) begin qa.push_back(d_saddr); qd.push_back(d_sdata); end
    end
  endtask

  task automatic step();
    bit eh;
    logic [DW-1:0] ed;
    @(negedge clk);
    wr_en = d_we; wr_idx = d_widx; wr_data = d_wdata; rd_idx = d_ridx;
    st_req = d_st; st_addr = d_saddr; st_data = d_sdata; ld_addr = d_laddr;
    commit = d_cm; rollback = d_rb;
    #1;
    chk(rd_data === wk[d_ridx], t_rd, 64'(rd_data), 64'(wk[d_ridx]));
    chk(cmt_ready === (ncmt == 0), "R7 cmt_ready", 64'(cmt_ready), 64'(ncmt == 0));
    chk(st_stall === (d_st && qa.size() == SBD), "R9 st_stall", 64'(st_stall),
        64'(d_st && qa.size() == SBD));
    chk(mem_we === (ncmt > 0), (ncmt > 0) ? "R6 mem_we" : "R5 mem_we", 64'(mem_we), 64'(ncmt > 0));
    if (ncmt > 0) begin
      chk(mem_addr === qa[0], "R6 mem_addr", 64'(mem_addr), 64'(qa[0]));
      chk(mem_data === qd[0], "R6 mem_data", 64'(mem_data), 64'(qd[0]));
    end
    eh = 0; ed = '0;
    for (int i = qa.size() - 1; i >= 0; i--) begin
      if (qa[i] == d_laddr) begin eh = 1; ed = qd[i]; break; end
    end
    chk(ld_hit === eh, t_ld, 64'(ld_hit), 64'(eh));
    if (eh) chk(ld_data === ed, t_ld, 64'(ld_data), 64'(ed));
    @(posedge clk);
    model_update();
  endtask

  task automatic read_all(string tag);
    t_rd = tag;
    for (int i = 0; i < NREG; i++) begin
      clr(); d_ridx = RIW'(i); step();
    end
    t_rd = "R2";
  endtask

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d);
    clr(); d_st = 1; d_saddr = a; d_sdata = d; step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) begin wk[i] = '0; sh[i] = '0; end
    clr(); d_widx = 0; d_ridx = 0; d_wdata = 0; d_sdata = 0; d_saddr = 0; d_laddr = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0; st_req = 0; st_addr = 0;
    st_data = 0; ld_addr = 0; commit = 0; rollback = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state.
    t_ld = "R1"; read_all("R1"); t_ld = "R10";

    // R3: commit with same-cycle write, then rollback exposes the checkpoint.
    for (int i = 0; i < NREG; i++) begin
      clr(); d_we = 1; d_widx = RIW'(i); d_wdata = 32'(100 + i); step();
    end
    clr(); d_cm = 1; d_we = 1; d_widx = 1; d_wdata = 32'hdead; step();
    clr(); d_rb = 1; step();
    read_all("R3");

    // R4: rollback discards prior and same-cycle writes.
    clr(); d_we = 1; d_widx = 2; d_wdata = 32'h55; step();
    clr(); d_rb = 1; d_we = 1; d_widx = 3; d_wdata = 32'h77; step();
    read_all("R4");

    // R5 / R10: stores held; youngest match forwarded.
    store(16'd1, 32'ha1); store(16'd2, 32'hb2);
    repeat (3) begin clr(); step(); end
    store(16'd1, 32'hc3);
    clr(); d_laddr = 16'd1; step();

    // R11: both commands together act as rollback.
    t_ld = "R11";
    clr(); d_cm = 1; d_rb = 1; d_we = 1; d_widx = 0; d_wdata = 32'h99;
    d_st = 1; d_saddr = 16'd1; d_sdata = 32'hee; step();
    clr(); d_laddr = 16'd1; step();
    t_ld = "R10";
    read_all("R11");

    // R6 / R7: commit releases three stores; commit during drain ignored.
    store(16'd3, 32'h31); store(16'd4, 32'h41); store(16'd5, 32'h51);
    clr(); d_cm = 1; step();
    clr(); d_cm = 1; d_we = 1; d_widx = 4; d_wdata = 32'h444;
    d_st = 1; d_saddr = 16'd6; d_sdata = 32'h61; step();
    repeat (3) begin clr(); step(); end
    clr(); d_rb = 1; step();
    read_all("R7");

    // R8: rollback in mid-drain keeps released entries, drops the rest.
    t_ld = "R8";
    store(16'd7, 32'h71); store(16'd3, 32'h72);
    clr(); d_cm = 1; step();
    store(16'd7, 32'h73);
    clr(); d_rb = 1; d_st = 1; d_saddr = 16'd3; d_sdata = 32'h74; d_laddr = 16'd7; step();
    repeat (3) begin clr(); d_laddr = 16'd3; step(); end
    t_ld = "R10";

    // R9: fill then overflow.
    for (int i = 0; i < SBD + 2; i++) store(AW'(i), 32'(200 + i));
    clr(); d_laddr = 16'd0; step();
    clr(); d_rb = 1; step();

    // Random mix.
    for (int n = 0; n < 4000; n++) begin
      clr();
      d_we    = 1'($urandom % 2);
      d_widx  = RIW'($urandom);
      d_wdata = $urandom;
      d_ridx  = RIW'($urandom);
      d_st    = ($urandom % 3) == 0;
      d_saddr = AW'($urandom % 8);
      d_sdata = $urandom;
      d_laddr = AW'($urandom % 8);
      d_cm    = ($urandom % 7) == 0;
      d_rb    = ($urandom % 13) == 0;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule